// File: doc/BRIEF.md
# Virtual Page Translator

This block turns a 32-bit virtual byte address into a 24-bit primary-memory byte address by consulting a page table kept in an external memory. Each request carries the address, a write flag and the base index of the requesting job's table. The block adds that base to the virtual page number (the upper 18 address bits) to find the table entry. It reads the entry once, then answers with a single-cycle completion pulse.

A table entry is 20 bits wide: bit 19 is the resident flag, bit 18 is the modified flag and bits 17..0 are a location field. When the resident flag is set, the low 10 bits of the location field name the page frame. The frame is joined to the 14 unchanged offset bits (block, word and byte within the page) to form the physical address. When the flag is clear, the block reports a page fault and returns the whole location field as a pointer into secondary storage. A write that lands on a resident page whose modified flag is still clear writes the entry back with that flag set. Choosing pages to evict and moving data to and from disk are left to the surrounding system.

Top module: `vpageTranslator`

## Requirements
- R1: After reset, `done`, `busy`, `memRdEn` and `memWrEn` are all 0.
- R2: An accepted request causes exactly one table read. It is issued in the cycle after acceptance, at address `tblBase + reqAddr[31:14]` modulo 2^18, using the base and address sampled at acceptance.
- R3: For a resident entry (bit 19 = 1), `fault` is 0 with `done`, and `physAddr` equals entry bits 9..0 followed by `reqAddr[13:0]`.
- R4: For a non-resident entry (bit 19 = 0), `fault` is 1 with `done`, and `secPtr` equals entry bits 17..0. This holds for reads and writes alike.
- R5: A write request whose entry is resident with bit 18 clear causes one table write to the same index. The written data is the entry with bit 18 set and all other bits unchanged, and it happens before `done`.
- R6: A read request, a write to an entry whose bit 18 is already set, and a write to a non-resident entry cause no table write.
- R7: `done` rises 3 cycles after the accepting clock edge when no write-back occurs, and 4 cycles after it when a write-back occurs.
- R8: A request is accepted only while `busy` is 0. A `reqValid` raised while busy is ignored and causes no extra table read.
- R9: `done` is a one-cycle pulse. `busy` stays high from acceptance through the `done` cycle and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request, accepted when not busy |
| reqAddr | input | 32 | Virtual byte address |
| reqWrite | input | 1 | 1 for a write access |
| tblBase | input | 18 | Page-table base index of the requesting job |
| busy | output | 1 | Translation in progress |
| memRdEn | output | 1 | Table read strobe; data is returned on the next cycle |
| memWrEn | output | 1 | Table write strobe |
| memAddr | output | 18 | Table entry index |
| memWrData | output | 20 | Entry written back |
| memRdData | input | 20 | Entry returned one cycle after `memRdEn` |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Page not resident, valid with `done` |
| physAddr | output | 24 | Physical byte address, valid with `done` when no fault |
| secPtr | output | 18 | Secondary-storage location, valid with `done` on a fault |

## Verification
The assertions check on every cycle that each table read targets the base-plus-page index sampled one cycle earlier. They also check that reads are single-cycle and never overlap a write, that every write-back carries both the resident and modified flags and follows a read by two cycles, that `done` is a lone pulse arriving 3 or 4 cycles after acceptance, and that a hit keeps the original offset bits. The bench scenarios cover what depends on the table's contents: the frame and pointer values and the choice between setting the modified flag and leaving the entry alone. They also cover base-index wraparound, high page numbers, and requests pushed while busy that must leave no trace.

// File: rtl/vptPkg.sv
package vptPkg;

  typedef struct packed {
    logic capReq;  // latch index, offset and write flag
    logic capEnt;  // latch the entry returned by table memory
  } vptStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_EVAL  = 3'd2,
    ST_WBACK = 3'd3,
    ST_FIN   = 3'd4
  } vptStateT;

endpackage

// File: rtl/vptDatapath.sv
module vptDatapath
  import vptPkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 14,
  parameter int TBL_AW  = 18,
  parameter int LOC_W   = 18,
  parameter int FRAME_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  vptStrobeT                stb,
  input  logic [VA_W-1:0]          reqAddr,
  input  logic [TBL_AW-1:0]        tblBase,
  input  logic [LOC_W+1:0]         memRdData,
  output logic                     rawValid,
  output logic                     rawDirty,
  output logic [TBL_AW-1:0]        memAddr,
  output logic [LOC_W+1:0]         memWrData,
  output logic [FRAME_W+OFF_W-1:0] physAddr,
  output logic                     fault,
  output logic [LOC_W-1:0]         secPtr
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int ENT_W   = LOC_W + 2;
  localparam int VAL_BIT = LOC_W + 1;
  localparam int DRT_BIT = LOC_W;

  logic [VPN_W-1:0]  vpn;
  logic [TBL_AW-1:0] idxSum;
  logic [TBL_AW-1:0] idxQ;
  logic [OFF_W-1:0]  offQ;
  logic [ENT_W-1:0]  entQ;

  assign vpn    = reqAddr[VA_W-1:OFF_W];
  assign idxSum = tblBase + TBL_AW'(vpn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      offQ <= '0;
      entQ <= '0;
    end else begin
      if (stb.capReq) begin
        idxQ <= idxSum;
        offQ <= reqAddr[OFF_W-1:0];
      end
      if (stb.capEnt) entQ <= memRdData;
    end
  end

  // flags seen by control in the cycle the entry arrives
  assign rawValid = memRdData[VAL_BIT];
  assign rawDirty = memRdData[DRT_BIT];

  assign memAddr = idxQ;

  always_comb begin
    memWrData          = entQ;
    memWrData[DRT_BIT] = 1'b1;
  end

  assign physAddr = {entQ[FRAME_W-1:0], offQ};
  assign fault    = ~entQ[VAL_BIT];
  assign secPtr   = entQ[LOC_W-1:0];

endmodule

// File: rtl/vptControl.sv
module vptControl
  import vptPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      rawValid,
  input  logic      rawDirty,
  output vptStrobeT stb,
  output logic      memRdEn,
  output logic      memWrEn,
  output logic      done,
  output logic      busy
);
  vptStateT state, nextState;
  logic     writeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      writeQ <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.capReq) writeQ <= reqWrite;
    end
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    memRdEn   = 1'b0;
    memWrEn   = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.capReq = 1'b1;
          nextState  = ST_READ;
        end
      end
      ST_READ: begin
        memRdEn   = 1'b1;
        nextState = ST_EVAL;
      end
      ST_EVAL: begin
        stb.capEnt = 1'b1;
        nextState  = (rawValid && writeQ && !rawDirty) ? ST_WBACK : ST_FIN;
      end
      ST_WBACK: begin
        memWrEn   = 1'b1;
        nextState = ST_FIN;
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/vpageTranslator.sv
module vpageTranslator
  import vptPkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 14,
  parameter int TBL_AW  = 18,
  parameter int LOC_W   = 18,
  parameter int FRAME_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [VA_W-1:0]          reqAddr,
  input  logic                     reqWrite,
  input  logic [TBL_AW-1:0]        tblBase,
  output logic                     busy,
  output logic                     memRdEn,
  output logic                     memWrEn,
  output logic [TBL_AW-1:0]        memAddr,
  output logic [LOC_W+1:0]         memWrData,
  input  logic [LOC_W+1:0]         memRdData,
  output logic                     done,
  output logic                     fault,
  output logic [FRAME_W+OFF_W-1:0] physAddr,
  output logic [LOC_W-1:0]         secPtr
);
  vptStrobeT stb;
  logic      rawValid;
  logic      rawDirty;

  vptControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .rawValid (rawValid),
    .rawDirty (rawDirty),
    .stb      (stb),
    .memRdEn  (memRdEn),
    .memWrEn  (memWrEn),
    .done     (done),
    .busy     (busy)
  );

  vptDatapath #(
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .TBL_AW  (TBL_AW),
    .LOC_W   (LOC_W),
    .FRAME_W (FRAME_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .tblBase   (tblBase),
    .memRdData (memRdData),
    .rawValid  (rawValid),
    .rawDirty  (rawDirty),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .physAddr  (physAddr),
    .fault     (fault),
    .secPtr    (secPtr)
  );

endmodule

// File: rtl/vptChecker.sv
module vptChecker #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 14,
  parameter int TBL_AW  = 18,
  parameter int LOC_W   = 18,
  parameter int FRAME_W = 10
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqValid,
  input logic [VA_W-1:0]          reqAddr,
  input logic [TBL_AW-1:0]        tblBase,
  input logic                     busy,
  input logic                     memRdEn,
  input logic                     memWrEn,
  input logic [TBL_AW-1:0]        memAddr,
  input logic [LOC_W+1:0]         memWrData,
  input logic                     done,
  input logic                     fault,
  input logic [FRAME_W+OFF_W-1:0] physAddr
);
  logic             accept;
  logic [2:0]       ageCnt;
  logic [OFF_W-1:0] offSeen;
  logic [TBL_AW-1:0] idxExp;

  assign accept = reqValid && !busy;
  assign idxExp = tblBase + TBL_AW'(reqAddr[VA_W-1:OFF_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ageCnt  <= '0;
      offSeen <= '0;
    end else if (accept) begin
      ageCnt  <= 3'd1;
      offSeen <= reqAddr[OFF_W-1:0];
    end else if (busy && ageCnt != 3'd7) begin
      ageCnt <= ageCnt + 3'd1;
    end
  end

  // R2
  rd_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memAddr == $past(idxExp) && $past(accept)));

  // R2
  rd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R5
  wb_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrData[LOC_W+1] && memWrData[LOC_W] && !memRdEn));

  // R5
  wb_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(memRdEn, 2));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ageCnt == 3'd3 || ageCnt == 3'd4));

  // R3
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (physAddr[OFF_W-1:0] == offSeen));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

bind vpageTranslator vptChecker #(
  .VA_W    (VA_W),
  .OFF_W   (OFF_W),
  .TBL_AW  (TBL_AW),
  .LOC_W   (LOC_W),
  .FRAME_W (FRAME_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .tblBase   (tblBase),
  .busy      (busy),
  .memRdEn   (memRdEn),
  .memWrEn   (memWrEn),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .done      (done),
  .fault     (fault),
  .physAddr  (physAddr)
);

// File: tb/tb_vpageTranslator.sv
module tb_vpageTranslator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [17:0] tblBase = '0;
  logic        busy, memRdEn, memWrEn, done, fault;
  logic [17:0] memAddr, secPtr;
  logic [19:0] memWrData;
  logic [19:0] memRdData = '0;
  logic [23:0] physAddr;

  int nChecks = 0;
  int nFails = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  logic [17:0] rdAddrSeen = '0;
  logic [19:0] tbl [int];

  always #5 clk = ~clk;

  vpageTranslator dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .tblBase(tblBase), .busy(busy), .memRdEn(memRdEn),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .done(done), .fault(fault),
    .physAddr(physAddr), .secPtr(secPtr)
  );

  // table memory model: one-cycle read latency
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= tbl.exists(int'(memAddr)) ? tbl[int'(memAddr)] : 20'h0;
      rdAddrSeen <= memAddr;
      rdCnt = rdCnt + 1;
    end
    if (memWrEn) begin
      tbl[int'(memAddr)] = memWrData;
      wrCnt = wrCnt + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] peek(input logic [17:0] idx);
    return tbl.exists(int'(idx)) ? tbl[int'(idx)] : 20'h0;
  endfunction

  // one translation; expected results derived from the table model
  task automatic xlate(input logic wr, input logic [31:0] va, input logic [17:0] base,
                       input logic pushWhileBusy);
    logic [17:0] idx;
    logic [19:0] ent;
    logic        expWb;
    int          lat, rd0, wr0;
    idx   = base + va[31:14];
    ent   = peek(idx);
    expWb = ent[19] && wr && !ent[18];
    @(negedge clk);
    reqValid = 1'b1; reqAddr = va; reqWrite = wr; tblBase = base;
    rd0 = rdCnt; wr0 = wrCnt;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      reqValid = pushWhileBusy && (lat < 3);
      if (pushWhileBusy) begin
        reqAddr = va ^ 32'h0004_C000; reqWrite = ~wr; tblBase = base + 18'd7;
      end
    end while (!done && lat < 10);
    reqValid = 1'b0;
    check("R7 latency", lat, expWb ? 4 : 3);
    check("R2 single read", rdCnt - rd0, 1);
    check("R2 read index", rdAddrSeen, idx);
    if (ent[19]) begin
      check("R3 fault flag", fault, 0);
      check("R3 physical address", physAddr, {ent[9:0], va[13:0]});
    end else begin
      check("R4 fault flag", fault, 1);
      check("R4 secondary pointer", secPtr, ent[17:0]);
    end
    if (expWb) begin
      check("R5 one write-back", wrCnt - wr0, 1);
      check("R5 entry dirty", peek(idx), ent | 20'h40000);
    end else begin
      check("R6 no write-back", wrCnt - wr0, 0);
      check("R6 entry unchanged", peek(idx), ent);
    end
    @(negedge clk);
    check("R9 done pulse", done, 0);
    check(pushWhileBusy ? "R8 stray request ignored" : "R9 busy low", busy, 0);
    if (pushWhileBusy) check("R8 no extra read", rdCnt - rd0, 1);
  endtask

  task automatic testReset();
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 memRdEn", memRdEn, 0);
    check("R1 memWrEn", memWrEn, 0);
  endtask

  task automatic testResidentRead();
    xlate(1'b0, {18'd5, 14'h1ABC}, 18'h00100, 1'b0);              // R3
    xlate(1'b0, {18'h20003, 14'h0007}, 18'h00100, 1'b0);          // R3 high page
  endtask

  task automatic testFaults();
    xlate(1'b0, {18'd6, 14'h2222}, 18'h00100, 1'b0);              // R4 read
    xlate(1'b1, {18'd9, 14'h0001}, 18'h00100, 1'b0);              // R4 write, R6
  endtask

  task automatic testWrites();
    xlate(1'b1, {18'd7, 14'h3FFF}, 18'h00100, 1'b0);              // R5
    xlate(1'b1, {18'd7, 14'h0000}, 18'h00100, 1'b0);              // R6 now dirty
    xlate(1'b1, {18'd8, 14'h1234}, 18'h00100, 1'b0);              // R6 preset dirty
  endtask

  task automatic testBaseWrap();
    xlate(1'b0, {18'h00020, 14'h0ABC}, 18'h3FFF0, 1'b0);          // R2 wrap to 0x10
  endtask

  task automatic testBusyIgnore();
    xlate(1'b0, {18'd5, 14'h0F0F}, 18'h00100, 1'b1);              // R8
    xlate(1'b1, {18'h00021, 14'h0011}, 18'h3FFF0, 1'b1);          // R8 with write-back
  endtask

  initial begin
    tbl[int'(18'h00105)] = {1'b1, 1'b0, 18'h002A5};
    tbl[int'(18'h20103)] = {1'b1, 1'b0, 18'h00001};
    tbl[int'(18'h00106)] = {1'b0, 1'b0, 18'h2C0DE};
    tbl[int'(18'h00107)] = {1'b1, 1'b0, 18'h00133};
    tbl[int'(18'h00108)] = {1'b1, 1'b1, 18'h0007F};
    tbl[int'(18'h00109)] = {1'b0, 1'b0, 18'h1F00F};
    tbl[int'(18'h00010)] = {1'b1, 1'b0, 18'h003FF};
    tbl[int'(18'h00011)] = {1'b1, 1'b0, 18'h00200};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testResidentRead();
    testFaults();
    testWrites();
    testBaseWrap();
    testBusyIgnore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule